// File: doc/BRIEF.md
# Ramped duty PWM channel

This block drives one output pin of a multi-channel pulse generator. A shared timebase, outside the block, supplies a period-start strobe and the period length in clock cycles. Inside each period the channel counts its own position and keeps the pin high while that position is below a threshold. The threshold is derived from the current duty, which is given in tenths of a percent (0 to 1000 per mille).

Software writes a target duty and a ramp time through a small register write port. The ramp time is counted in 10 ms units. When the ramp time is zero, a new target takes effect at once. Otherwise the current duty walks toward the target in equal 10 ms steps and lands on it exactly. A ramp-busy flag shows when a walk is in progress. A mode input selects either the modulated waveform or a plain static level on the pin.

Top module: `ramped_pwm_channel`

## Requirements
- R1: After reset the target duty, the current duty and the stored ramp time are 0, `ramp_busy` is 0, and in PWM mode the pin stays low for a whole period.
- R2: A write with `cfg_sel`=0 sets the target duty and a write with `cfg_sel`=1 sets the ramp time (in 10 ms steps). Both use the full 16-bit `cfg_wdata`. A duty value above 1000 is treated as 1000.
- R3: For a period of L cycles, the pin is high for exactly floor(duty·L/1000) cycles, counted from the first cycle after the strobe. Duty 0 gives a pin that stays low. Duty 1000 gives a pin that stays high, even past the end of the period.
- R4: The threshold is taken from the current duty only on the clock edge that sees `frame_start`. A duty change in the middle of a period leaves that period's high time unchanged and shows up in the next period.
- R5: With a stored ramp time of 0, a duty write sets the current duty to the target on the write edge and clears `ramp_busy`, even if a ramp was running.
- R6: With a ramp time N>0, a duty write raises `ramp_busy` on the write edge. Every 10th `tick_1ms` pulse after that adds trunc((target−current)/remaining) to the duty, where remaining counts down from N. The duty equals the target after N steps, and `ramp_busy` falls on that last step.
- R7: Rewriting the ramp time during a ramp does not change the number of steps in that ramp. The new value applies to the next duty write.
- R8: A duty write during a ramp starts a new ramp from the present current duty, using the ramp time stored at that moment.
- R9: With `pwm_mode`=0 the pin follows `level_out` combinationally. With `pwm_mode`=1 it carries the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe that starts a period |
| frame_len | input | 16 | Period length in clock cycles |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects target duty, 1 selects ramp time |
| cfg_wdata | input | 16 | Write data |
| pwm_mode | input | 1 | 1 selects PWM, 0 selects static level |
| level_out | input | 1 | Static level used when not in PWM mode |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| pin_out | output | 1 | Channel output pin |
| ramp_busy | output | 1 | High while a duty ramp is in progress |

## Verification
A duty write or ramp step changes the internal duty on the same clock edge. The pin shows the change only from the period whose strobe edge comes after that edge, so the checks measure a whole period that the bench starts after the write or the tenth tick. `ramp_busy` is registered on the write edge or the final step edge, and the bench samples it at the falling clock edge that follows. The mode multiplexer is combinational, so the pin is sampled one nanosecond after `pwm_mode` or `level_out` changes. Expected high counts come from a step-by-step duty model kept in the bench, which applies the truncated quotient by working on magnitude and sign.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;

  localparam int DUTY_W    = 10;
  localparam int DUTY_FULL = 1000;
  localparam int CFG_W     = 16;

  typedef logic [DUTY_W-1:0] duty_t;

  typedef enum logic {
    SEL_DUTY = 1'b0,
    SEL_RAMP = 1'b1
  } cfg_sel_e;

  // Limit a raw written value to the legal per-mille range.
  function automatic duty_t duty_clamp(input logic [CFG_W-1:0] raw);
    if (raw > CFG_W'(DUTY_FULL)) return duty_t'(DUTY_FULL);
    return duty_t'(raw);
  endfunction

  // Next duty after one ramp step: move by the remaining gap split evenly
  // over the remaining steps (quotient truncated toward zero).
  function automatic duty_t ramp_next(input duty_t cur, input duty_t tgt,
                                      input logic [CFG_W-1:0] left);
    int gap;
    int inc;
    if (left == '0) return tgt;
    gap = int'(tgt) - int'(cur);
    inc = gap / int'(left);
    return duty_t'(int'(cur) + inc);
  endfunction

endpackage

// File: rtl/rpwm_regs.sv
module rpwm_regs
  import rpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             duty_load,
  output duty_t            duty_value,
  output logic [CFG_W-1:0] ramp_steps
);

  logic ramp_we;

  assign duty_load  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_DUTY);
  assign ramp_we    = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_RAMP);
  assign duty_value = duty_clamp(cfg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ramp_steps <= '0;
    else if (ramp_we) ramp_steps <= cfg_wdata;
  end

  // R2: a stored ramp time changes only on a ramp-time write
  assert_ramp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_we |=> $stable(ramp_steps))
    else $error("ramp time changed without a write");

  // R2: the duty handed on never exceeds full scale
  assert_duty_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    duty_load |-> (duty_value <= duty_t'(DUTY_FULL)))
    else $error("duty value above full scale");

endmodule

// File: rtl/rpwm_ramp.sv
module rpwm_ramp
  import rpwm_pkg::*;
#(
  parameter int TICKS_PER_STEP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             duty_load,
  input  duty_t            duty_value,
  input  logic [CFG_W-1:0] ramp_steps,
  input  logic             tick_1ms,
  output duty_t            duty_cur,
  output duty_t            duty_tgt,
  output logic             busy,
  output logic             step_evt
);

  localparam int PRE_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_STEP - 1);

  logic [CFG_W-1:0] steps_left;
  logic [PRE_W-1:0] pre_cnt;
  logic             load_now;
  logic             load_ramped;

  assign busy        = (steps_left != '0);
  assign step_evt    = busy && tick_1ms && (pre_cnt == PRE_LAST);
  assign load_now    = duty_load && (ramp_steps == '0);
  assign load_ramped = duty_load && (ramp_steps != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_cur   <= '0;
      duty_tgt   <= '0;
      steps_left <= '0;
      pre_cnt    <= '0;
    end else if (load_now) begin
      duty_cur   <= duty_value;
      duty_tgt   <= duty_value;
      steps_left <= '0;
      pre_cnt    <= '0;
    end else if (load_ramped) begin
      duty_tgt   <= duty_value;
      steps_left <= ramp_steps;
      pre_cnt    <= '0;
    end else if (step_evt) begin
      duty_cur   <= ramp_next(duty_cur, duty_tgt, steps_left);
      steps_left <= steps_left - 1'b1;
      pre_cnt    <= '0;
    end else if (busy && tick_1ms) begin
      pre_cnt    <= pre_cnt + 1'b1;
    end
  end

  // R5: a zero ramp time applies the written duty on the write edge
  assert_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (duty_cur == $past(duty_value)) && !busy)
    else $error("zero ramp time did not apply duty at once");

  // R6: each step moves the duty without overshooting the target
  assert_step_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !duty_load) |=>
      (($past(duty_cur) <= $past(duty_tgt)) ?
        ((duty_cur >= $past(duty_cur)) && (duty_cur <= $past(duty_tgt))) :
        ((duty_cur <= $past(duty_cur)) && (duty_cur >= $past(duty_tgt)))))
    else $error("ramp step left the interval toward the target");

  // R6: when a ramp finishes, the duty sits exactly on the target
  assert_ramp_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (duty_cur == duty_tgt))
    else $error("ramp ended off target");

  // R6: between steps and loads, the current duty holds
  assert_duty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!duty_load && !step_evt) |=> $stable(duty_cur))
    else $error("duty changed outside a step or load");

  // R7: the remaining step count only falls while no duty write happens
  assert_steps_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!duty_load && busy) |=> (steps_left <= $past(steps_left)))
    else $error("ramp step count grew during a ramp");

endmodule

// File: rtl/rpwm_compare.sv
module rpwm_compare
  import rpwm_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [PERIOD_W-1:0] frame_len,
  input  duty_t               duty_cur,
  output logic                wave,
  output logic [PERIOD_W-1:0] thr
);

  localparam int PROD_W = PERIOD_W + DUTY_W;
  localparam logic [PERIOD_W-1:0] POS_MAX = '1;

  logic [PERIOD_W-1:0] pos;
  logic                full_q;

  // Number of high cycles for a duty over a period of len cycles.
  function automatic logic [PERIOD_W-1:0] high_cycles(input duty_t d,
                                                      input logic [PERIOD_W-1:0] len);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(d) * PROD_W'(len);
    return PERIOD_W'(prod / PROD_W'(DUTY_FULL));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= POS_MAX;
      thr    <= '0;
      full_q <= 1'b0;
    end else if (frame_start) begin
      pos    <= '0;
      thr    <= high_cycles(duty_cur, frame_len);
      full_q <= (duty_cur == duty_t'(DUTY_FULL));
    end else if (pos != POS_MAX) begin
      pos    <= pos + 1'b1;
    end
  end

  assign wave = full_q || (pos < thr);

  // R4: the threshold moves only on a period strobe
  assert_thr_glitchfree_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(thr) && $stable(full_q))
    else $error("threshold changed inside a period");

  // R3: the latched threshold never exceeds the period length
  assert_thr_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (thr <= $past(frame_len)))
    else $error("threshold beyond period length");

endmodule

// File: rtl/ramped_pwm_channel.sv
module ramped_pwm_channel
  import rpwm_pkg::*;
#(
  parameter int PERIOD_W       = 16,
  parameter int TICKS_PER_STEP = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [PERIOD_W-1:0] frame_len,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                pwm_mode,
  input  logic                level_out,
  input  logic                tick_1ms,
  output logic                pin_out,
  output logic                ramp_busy
);

  logic             duty_load;
  duty_t            duty_value;
  logic [CFG_W-1:0] ramp_steps;
  duty_t            duty_cur;
  duty_t            duty_tgt;
  logic             step_evt;
  logic             wave;
  logic [PERIOD_W-1:0] thr;

  rpwm_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .duty_load  (duty_load),
    .duty_value (duty_value),
    .ramp_steps (ramp_steps)
  );

  rpwm_ramp #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .duty_load  (duty_load),
    .duty_value (duty_value),
    .ramp_steps (ramp_steps),
    .tick_1ms   (tick_1ms),
    .duty_cur   (duty_cur),
    .duty_tgt   (duty_tgt),
    .busy       (ramp_busy),
    .step_evt   (step_evt)
  );

  rpwm_compare #(.PERIOD_W(PERIOD_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_len   (frame_len),
    .duty_cur    (duty_cur),
    .wave        (wave),
    .thr         (thr)
  );

  assign pin_out = pwm_mode ? wave : level_out;

  // R1: no ramp can be in progress with the target equal to the duty and no write
  assert_idle_settled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_busy && !duty_load) |=> !ramp_busy && (duty_cur == duty_tgt))
    else $error("idle channel with unsettled duty");

  // R3: full duty latched at a strobe keeps the waveform high
  assert_full_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && duty_cur == duty_t'(DUTY_FULL)) |=> wave)
    else $error("full duty did not drive the waveform high");

  // R3: zero duty latched at a strobe keeps the waveform low
  assert_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && duty_cur == '0) |=> (!wave && thr == '0))
    else $error("zero duty produced a pulse");

  // R6: steps happen only while a ramp is in progress
  assert_step_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> ramp_busy)
    else $error("step outside a ramp");

endmodule

// File: tb/ramped_pwm_channel_tb.sv
`timescale 1ns/1ps
module ramped_pwm_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [15:0] frame_len = 16'd100;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        pwm_mode = 1'b1;
  logic        level_out = 1'b0;
  logic        tick_1ms = 1'b0;
  logic        pin_out;
  logic        ramp_busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench duty model
  int m_cur = 0, m_tgt = 0, m_left = 0, m_ramp = 0, m_pre = 0;

  always #10 clk = ~clk;

  ramped_pwm_channel u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_len(frame_len),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pwm_mode(pwm_mode), .level_out(level_out), .tick_1ms(tick_1ms),
    .pin_out(pin_out), .ramp_busy(ramp_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_high(input int duty, input int len);
    return (duty * len) / 1000;
  endfunction

  // magnitude-and-sign form of the step rule
  task automatic model_step();
    int gap, mag, inc;
    gap = m_tgt - m_cur;
    mag = (gap < 0) ? -gap : gap;
    inc = mag / m_left;
    m_cur = (gap < 0) ? m_cur - inc : m_cur + inc;
    m_left--;
  endtask

  task automatic cfg_write(input bit sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_ramp = val;
    else begin
      m_tgt = (val > 1000) ? 1000 : val;
      m_pre = 0;
      if (m_ramp == 0) begin m_cur = m_tgt; m_left = 0; end
      else m_left = m_ramp;
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_1ms = 1'b1;
      @(negedge clk); tick_1ms = 1'b0;
      if (m_left > 0) begin
        m_pre++;
        if (m_pre == 10) begin m_pre = 0; model_step(); end
      end
    end
  endtask

  task automatic run_period(input int len, input int span, output int hi);
    hi = 0;
    frame_len = 16'(len);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int i = 0; i < span; i++) begin
      if (i > 0) @(negedge clk);
      if (pin_out) hi++;
    end
  endtask

  task automatic t_reset();
    int hi;
    check(ramp_busy == 1'b0, "R1 busy after reset", int'(ramp_busy), 0);
    run_period(100, 100, hi);
    check(hi == 0, "R1 pin low after reset", hi, 0);
  endtask

  task automatic t_mode();
    pwm_mode = 1'b0; level_out = 1'b1; #1;
    check(pin_out == 1'b1, "R9 static level high", int'(pin_out), 1);
    level_out = 1'b0; #1;
    check(pin_out == 1'b0, "R9 static level low", int'(pin_out), 0);
    cfg_write(1'b0, 1000);
    level_out = 1'b0; #1;
    check(pin_out == 1'b0, "R9 static level ignores duty", int'(pin_out), 0);
    pwm_mode = 1'b1; #1;
    cfg_write(1'b0, 0);
  endtask

  task automatic t_immediate();
    int hi;
    cfg_write(1'b1, 0);
    cfg_write(1'b0, 250);
    check(ramp_busy == 1'b0, "R5 no busy with zero ramp", int'(ramp_busy), 0);
    run_period(200, 200, hi);
    check(hi == exp_high(m_cur, 200), "R3 duty 250 of 200", hi, exp_high(m_cur, 200));
    cfg_write(1'b0, 333);
    run_period(7, 7, hi);
    check(hi == 2, "R3 duty 333 of 7 floors", hi, 2);
    cfg_write(1'b0, 0);
    run_period(50, 60, hi);
    check(hi == 0, "R3 duty 0 constant low", hi, 0);
    cfg_write(1'b0, 1500);
    run_period(64, 80, hi);
    check(hi == 80, "R2 clamp 1500 to full, R3 constant high", hi, 80);
  endtask

  task automatic t_glitch();
    int hi;
    cfg_write(1'b0, 400);
    run_period(100, 100, hi);
    check(hi == 40, "R4 baseline duty 400", hi, 40);
    hi = 0;
    frame_len = 16'd100;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (i > 0) @(negedge clk);
      if (pin_out) hi++;
      if (i == 10) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'd900; end
      if (i == 11) cfg_we = 1'b0;
    end
    m_cur = 900; m_tgt = 900;
    check(hi == 40, "R4 mid-period write keeps period", hi, 40);
    run_period(100, 100, hi);
    check(hi == 90, "R4 new duty in next period", hi, 90);
  endtask

  task automatic t_ramp();
    int hi;
    cfg_write(1'b1, 3);
    cfg_write(1'b0, 300);
    check(ramp_busy == 1'b1, "R6 busy on write edge", int'(ramp_busy), 1);
    run_period(1000, 1000, hi);
    check(hi == 900, "R6 duty unchanged before steps", hi, 900);
    ticks(9);
    run_period(1000, 1000, hi);
    check(hi == 900, "R6 no step after 9 ticks", hi, 900);
    ticks(1);
    run_period(1000, 1000, hi);
    check(hi == m_cur && hi == 700, "R6 first step", hi, m_cur);
    ticks(10);
    check(ramp_busy == 1'b1, "R6 busy mid ramp", int'(ramp_busy), 1);
    ticks(10);
    check(ramp_busy == 1'b0, "R6 busy clears on last step", int'(ramp_busy), 0);
    run_period(1000, 1000, hi);
    check(hi == 300, "R6 lands on target", hi, 300);
    cfg_write(1'b0, 1000);
    ticks(10);
    run_period(1000, 1000, hi);
    check(hi == m_cur && hi == 533, "R6 uneven first step", hi, m_cur);
    ticks(10);
    run_period(1000, 1000, hi);
    check(hi == m_cur, "R6 uneven second step", hi, m_cur);
    ticks(10);
    run_period(1000, 1000, hi);
    check(hi == 1000 && !ramp_busy, "R6 uneven ramp exact end", hi, 1000);
  endtask

  task automatic t_rewrite();
    int hi;
    cfg_write(1'b1, 2);
    cfg_write(1'b0, 0);
    ticks(10);
    cfg_write(1'b1, 5);
    ticks(10);
    check(ramp_busy == 1'b0, "R7 ramp keeps its own step count", int'(ramp_busy), 0);
    run_period(1000, 1000, hi);
    check(hi == 0, "R7 ramp ended on target", hi, 0);
    cfg_write(1'b0, 500);
    ticks(10);
    run_period(1000, 1000, hi);
    check(hi == m_cur && hi == 100, "R7 next ramp uses new time", hi, m_cur);
    ticks(30);
    check(ramp_busy == 1'b1, "R7 five steps still running", int'(ramp_busy), 1);
    ticks(10);
    run_period(1000, 1000, hi);
    check(hi == 500 && !ramp_busy, "R7 five-step ramp done", hi, 500);
  endtask

  task automatic t_retarget();
    int hi;
    cfg_write(1'b0, 0);
    ticks(10);
    cfg_write(1'b0, 800);
    check(ramp_busy == 1'b1, "R8 restart keeps busy", int'(ramp_busy), 1);
    ticks(10);
    run_period(1000, 1000, hi);
    check(hi == m_cur && hi == 480, "R8 restart from current duty", hi, m_cur);
    cfg_write(1'b1, 0);
    cfg_write(1'b0, 200);
    check(ramp_busy == 1'b0, "R5 zero ramp cancels running ramp", int'(ramp_busy), 0);
    run_period(1000, 1000, hi);
    check(hi == 200, "R5 immediate duty after cancel", hi, 200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_immediate();
    t_glitch();
    t_ramp();
    t_rewrite();
    t_retarget();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule